// File: doc/BRIEF.md
# Data-Processing Operand Shifter

This block produces the second ALU operand for a 32-bit RISC data-processing instruction. It takes the instruction word, the values read for the operand register and the shift-amount register, the current program counter and the carry flag. It returns the 32-bit operand and the carry that the shifter produces. Three operand forms are decoded. The first is an 8-bit constant rotated by an even amount. The second is a register shifted by a 5-bit constant from the instruction. The third is a register shifted by an amount held in another register.

The block is more than a plain barrel shifter because it decodes the zero-amount special encodings. Depending on the shift type, a constant amount of zero means a shift by 32, a sign fill, or a one-bit rotate through the carry flag. It also gives defined results for register-held amounts of 32 and above. The decode and shift logic is combinational. The outputs are captured in one register stage, which is loaded only when an input is accepted with its valid strobe.

Top module: `operand_shifter`

## Requirements
- R1: When instruction bit 25 is 1, the operand is instruction bits 7:0, zero-extended and rotated right by twice the value of bits 11:8.
- R2: In the constant-rotate form the carry-out equals the carry flag when bits 11:8 are zero; otherwise it equals bit 31 of the operand.
- R3: In register forms, bits 3:0 select the operand register and bits 6:5 give the shift type (0 LSL, 1 LSR, 2 ASR, 3 ROR). Bit 4 clear takes the amount from bits 11:7. LSL by a nonzero constant gives the carry equal to the last bit shifted out. LSL by a constant zero passes the register through and gives the carry equal to the carry flag.
- R4: LSR by a constant zero acts as a shift by 32: the operand is zero and the carry is bit 31 of the register. A nonzero constant gives the carry equal to the last bit shifted out.
- R5: ASR by a constant zero fills all 32 bits with bit 31 of the register, and the carry is that bit. A nonzero ASR gives the carry equal to the last bit shifted out.
- R6: ROR by a constant zero is a one-bit rotate through carry: the operand is {carry flag, register[31:1]} and the carry is register bit 0. A nonzero ROR gives the carry equal to operand bit 31.
- R7: When bits 3:0 equal 15 in the constant-amount form, the value shifted is the program counter plus 8. In the register-amount form the operand register value is used as given.
- R8: When bit 4 is set, only bits 7:0 of the shift-amount register count. An amount of zero passes the register unchanged and gives the carry equal to the carry flag.
- R9: For a register-held amount, LSL by 32 gives zero with the carry equal to register bit 0. LSR by 32 gives zero with the carry equal to register bit 31. Either shift by more than 32 gives zero with a carry of zero.
- R10: For a register-held amount, ASR by 32 or more gives a sign fill with the carry equal to register bit 31.
- R11: For a register-held amount, ROR rotates by the amount modulo 32. A nonzero multiple of 32 returns the register unchanged, with the carry equal to its bit 31.
- R12: out_valid rises one cycle after in_valid. The operand and carry-out are loaded only in cycles when in_valid is high, and hold their values otherwise.
- R13: A synchronous active-low reset clears out_valid, the operand and the carry-out. It takes priority over an input offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Data-processing instruction word |
| rm_val | input | 32 | Value read from the operand register |
| rs_val | input | 32 | Value read from the shift-amount register |
| pc_val | input | 32 | Program counter of the instruction |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Operand and carry-out are valid |
| operand | output | 32 | Computed second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Reset and an accepted input can land on the same clock edge, and the register stage must let reset win. The bench holds in_valid high with a complete instruction while rst_n is low, both at start-up and in the middle of a run. It then confirms that out_valid, the operand and the carry are cleared rather than loaded. It also confirms that the first vector offered after reset is released produces the correct operand.

// File: rtl/opsh_pkg.sv
// Shared constants and types for the operand shifter.
// Assumes a 32-bit datapath with fixed instruction field positions.
package opsh_pkg;
    localparam int DW = 32;               // datapath width
    localparam int IW = 32;               // instruction width
    localparam int AW = $clog2(DW) + 1;   // amount width, holds 0..DW
    localparam int IMM_SEL_BIT = 25;      // constant-rotate form select
    localparam int REG_AMT_BIT = 4;       // register-held amount select

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_type_t;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_ASR,
        OP_ROR,
        OP_RRX,
        OP_ZERO
    } shift_op_t;
endpackage

// File: rtl/opsh_decode.sv
// Operand form decoder.
// Turns the instruction word and the register values into one normalised
// shift request: a source value, an operation and an amount in 1..DW.
// The zero-amount special encodings and the saturation of register-held
// amounts are resolved here, so the datapath sees no special cases.
// Assumes the instruction is a data-processing instruction.
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int PC_AHEAD = 8
) (
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] rm_val,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] pc_val,
    output shift_op_t     op_kind,
    output logic [AW-1:0] amount,
    output logic [DW-1:0] src
);
    logic        imm_form;
    logic        reg_amt;
    shift_type_t sh_type;
    logic [4:0]  imm_amt;
    logic [4:0]  rot_amt;
    logic [7:0]  rs_byte;
    logic        rm_is_pc;
    logic        unused_bits;

    assign imm_form    = instr[IMM_SEL_BIT];
    assign reg_amt     = instr[REG_AMT_BIT];
    assign sh_type     = shift_type_t'(instr[6:5]);
    assign imm_amt     = instr[11:7];
    assign rot_amt     = {instr[11:8], 1'b0};
    assign rs_byte     = rs_val[7:0];
    assign rm_is_pc    = (instr[3:0] == 4'hF);
    assign unused_bits = ^{instr[IW-1:IMM_SEL_BIT+1], instr[IMM_SEL_BIT-1:12], rs_val[DW-1:8]};

    // Select the form and normalise the special amounts.
    always_comb begin
        op_kind = OP_PASS;
        amount  = '0;
        src     = rm_val;
        if (imm_form) begin
            src = DW'(instr[7:0]);
            if (rot_amt != 5'd0) begin
                op_kind = OP_ROR;
                amount  = AW'(rot_amt);
            end
        end else if (!reg_amt) begin
            if (rm_is_pc) src = pc_val + DW'(PC_AHEAD);
            amount = AW'(imm_amt);
            unique case (sh_type)
                SH_LSL: op_kind = (imm_amt == 5'd0) ? OP_PASS : OP_LSL;
                SH_LSR: begin
                    op_kind = OP_LSR;
                    if (imm_amt == 5'd0) amount = AW'(DW);
                end
                SH_ASR: begin
                    op_kind = OP_ASR;
                    if (imm_amt == 5'd0) amount = AW'(DW);
                end
                SH_ROR: op_kind = (imm_amt == 5'd0) ? OP_RRX : OP_ROR;
            endcase
        end else if (rs_byte != 8'd0) begin
            unique case (sh_type)
                SH_LSL, SH_LSR: begin
                    if (32'(rs_byte) > DW) begin
                        op_kind = OP_ZERO;
                    end else begin
                        op_kind = (sh_type == SH_LSL) ? OP_LSL : OP_LSR;
                        amount  = AW'(rs_byte);
                    end
                end
                SH_ASR: begin
                    op_kind = OP_ASR;
                    amount  = (32'(rs_byte) > DW) ? AW'(DW) : AW'(rs_byte);
                end
                SH_ROR: begin
                    op_kind = OP_ROR;
                    amount  = (rs_byte[AW-2:0] == '0) ? AW'(DW) : AW'(rs_byte[AW-2:0]);
                end
            endcase
        end
    end
endmodule

// File: rtl/opsh_barrel.sv
// Shift datapath.
// Applies one normalised operation with an amount of 1..DW to the source.
// Each shift is widened by one bit, so the carry-out is simply the
// neighbouring bit of the widened result.
// Assumes the decoder never passes an amount of zero for LSL/LSR/ASR/ROR.
module opsh_barrel
    import opsh_pkg::*;
(
    input  shift_op_t     op_kind,
    input  logic [AW-1:0] amount,
    input  logic [DW-1:0] src,
    input  logic          carry_in,
    output logic [DW-1:0] result,
    output logic          carry
);
    logic [2*DW-1:0]      lsl_w;
    logic [DW:0]          lsr_w;
    logic signed [DW:0]   asr_w;
    logic [2*DW-1:0]      ror_w;
    logic                 unused_hi;

    assign lsl_w     = {{DW{1'b0}}, src} << amount;
    assign lsr_w     = {src, 1'b0} >> amount;
    assign asr_w     = $signed({src, 1'b0}) >>> amount;
    assign ror_w     = {src, src} >> amount;
    assign unused_hi = ^{lsl_w[2*DW-1:DW+1], ror_w[2*DW-1:DW]};

    // Pick the result and carry of the requested operation.
    always_comb begin
        result = src;
        carry  = carry_in;
        unique case (op_kind)
            OP_LSL: begin result = lsl_w[DW-1:0]; carry = lsl_w[DW]; end
            OP_LSR: begin result = lsr_w[DW:1];   carry = lsr_w[0];  end
            OP_ASR: begin result = asr_w[DW:1];   carry = asr_w[0];  end
            OP_ROR: begin result = ror_w[DW-1:0]; carry = ror_w[DW-1]; end
            OP_RRX: begin result = {carry_in, src[DW-1:1]}; carry = src[0]; end
            OP_ZERO: begin result = '0; carry = 1'b0; end
            default: begin result = src; carry = carry_in; end
        endcase
    end
endmodule

// File: rtl/operand_shifter.sv
// Data-processing operand shifter, top level.
// Decodes the operand form, shifts, and registers the operand and carry
// one cycle after an accepted input.
// Assumes the register values and carry are stable with in_valid.
module operand_shifter
    import opsh_pkg::*;
#(
    parameter int PC_AHEAD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] rm_val,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] pc_val,
    input  logic          carry_in,
    output logic          out_valid,
    output logic [DW-1:0] operand,
    output logic          carry_out
);
    shift_op_t     op_kind;
    logic [AW-1:0] amount;
    logic [DW-1:0] src;
    logic [DW-1:0] result;
    logic          carry;

    opsh_decode #(.PC_AHEAD(PC_AHEAD)) i_decode (
        .instr   (instr),
        .rm_val  (rm_val),
        .rs_val  (rs_val),
        .pc_val  (pc_val),
        .op_kind (op_kind),
        .amount  (amount),
        .src     (src)
    );

    opsh_barrel i_barrel (
        .op_kind  (op_kind),
        .amount   (amount),
        .src      (src),
        .carry_in (carry_in),
        .result   (result),
        .carry    (carry)
    );

    // Output stage: reset clears, an accepted input loads, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            operand   <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                operand   <= result;
                carry_out <= carry;
            end
        end
    end
endmodule

// File: rtl/operand_shifter_chk.sv
// Property checker for operand_shifter, bound to every instance.
// Assumes the port names of the top module.
module operand_shifter_chk
    import opsh_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [IW-1:0] instr,
    input logic [DW-1:0] rm_val,
    input logic [DW-1:0] rs_val,
    input logic [DW-1:0] pc_val,
    input logic          carry_in,
    input logic          out_valid,
    input logic [DW-1:0] operand,
    input logic          carry_out
);
    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && operand == '0 && !carry_out));

    // R2
    imm_norot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[IMM_SEL_BIT] && instr[11:8] == 4'h0)
        |=> (operand == DW'($past(instr[7:0])) && carry_out == $past(carry_in)));

    // R8
    rs_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[IMM_SEL_BIT] && instr[REG_AMT_BIT] && rs_val[7:0] == 8'h00)
        |=> (operand == $past(rm_val) && carry_out == $past(carry_in)));

    // R4
    lsr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[IMM_SEL_BIT] && !instr[REG_AMT_BIT]
         && instr[6:5] == 2'd1 && instr[11:7] == 5'd0)
        |=> (operand == '0));

    // R6
    rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[IMM_SEL_BIT] && !instr[REG_AMT_BIT]
         && instr[6:5] == 2'd3 && instr[11:7] == 5'd0 && instr[3:0] != 4'hF)
        |=> (operand == {$past(carry_in), $past(rm_val[DW-1:1])}
             && carry_out == $past(rm_val[0])));
endmodule

bind operand_shifter operand_shifter_chk i_chk (.*);

// File: tb/test_operand_shifter.sv
// Self-checking bench: a vector table walked back to back, then directed
// tests of reset, hold and latency.
module test_operand_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] pc_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    operand_shifter i_operand_shifter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rm_val(rm_val), .rs_val(rs_val), .pc_val(pc_val), .carry_in(carry_in),
        .out_valid(out_valid), .operand(operand), .carry_out(carry_out)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] ins;
        logic [31:0] rm;
        logic [31:0] rs;
        logic [31:0] pc;
        logic        ci;
        logic [31:0] op;
        logic        co;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  32'h020004FF, 32'h0,        32'h0,        32'h0,   1'b0, 32'hFF000000, 1'b1}, // R1 ror 8
        '{4'd2,  32'h02000080, 32'h0,        32'h0,        32'h0,   1'b1, 32'h00000080, 1'b1}, // R2 no rotate
        '{4'd1,  32'h0200013F, 32'h0,        32'h0,        32'h0,   1'b0, 32'hC000000F, 1'b1}, // R1 ror 2
        '{4'd2,  32'h02000F01, 32'h0,        32'h0,        32'h0,   1'b1, 32'h00000004, 1'b0}, // R2 bit31 clear
        '{4'd3,  32'h00000202, 32'hF000000F, 32'h0,        32'h0,   1'b0, 32'h000000F0, 1'b1}, // R3 lsl 4
        '{4'd3,  32'h00000003, 32'h12345678, 32'h0,        32'h0,   1'b1, 32'h12345678, 1'b1}, // R3 lsl 0
        '{4'd4,  32'h00000021, 32'h80000001, 32'h0,        32'h0,   1'b0, 32'h00000000, 1'b1}, // R4 lsr #0
        '{4'd4,  32'h00000421, 32'h00008180, 32'h0,        32'h0,   1'b0, 32'h00000081, 1'b1}, // R4 lsr 8
        '{4'd5,  32'h00000041, 32'h80000000, 32'h0,        32'h0,   1'b0, 32'hFFFFFFFF, 1'b1}, // R5 asr #0
        '{4'd5,  32'h00000241, 32'h80000010, 32'h0,        32'h0,   1'b1, 32'hF8000001, 1'b0}, // R5 asr 4
        '{4'd6,  32'h00000061, 32'h00000003, 32'h0,        32'h0,   1'b1, 32'h80000001, 1'b1}, // R6 rrx
        '{4'd6,  32'h00000261, 32'h0000000F, 32'h0,        32'h0,   1'b0, 32'hF0000000, 1'b1}, // R6 ror 4
        '{4'd7,  32'h0000008F, 32'h0000DEAD, 32'h0,        32'h100, 1'b1, 32'h00000210, 1'b0}, // R7 pc+8
        '{4'd7,  32'h0000041F, 32'h00000040, 32'h1,        32'h100, 1'b0, 32'h00000080, 1'b0}, // R7 reg form
        '{4'd8,  32'h00000431, 32'hABCD0000, 32'h00000100, 32'h0,   1'b1, 32'hABCD0000, 1'b1}, // R8 low byte 0
        '{4'd8,  32'h00000411, 32'h1000000F, 32'hFFFFFF04, 32'h0,   1'b0, 32'h000000F0, 1'b1}, // R8 low byte 4
        '{4'd9,  32'h00000411, 32'h00000001, 32'd32,       32'h0,   1'b0, 32'h00000000, 1'b1}, // R9 lsl 32
        '{4'd9,  32'h00000431, 32'h80000000, 32'd32,       32'h0,   1'b0, 32'h00000000, 1'b1}, // R9 lsr 32
        '{4'd9,  32'h00000411, 32'hFFFFFFFF, 32'd33,       32'h0,   1'b1, 32'h00000000, 1'b0}, // R9 lsl 33
        '{4'd9,  32'h00000431, 32'hFFFFFFFF, 32'h000000FF, 32'h0,   1'b1, 32'h00000000, 1'b0}, // R9 lsr 255
        '{4'd10, 32'h00000451, 32'h80000000, 32'd40,       32'h0,   1'b0, 32'hFFFFFFFF, 1'b1}, // R10 asr 40
        '{4'd10, 32'h00000451, 32'h7FFFFFFF, 32'd200,      32'h0,   1'b1, 32'h00000000, 1'b0}, // R10 asr 200
        '{4'd10, 32'h00000451, 32'h80000000, 32'd4,        32'h0,   1'b0, 32'hF8000000, 1'b0}, // R10 asr 4
        '{4'd11, 32'h00000471, 32'h80000001, 32'd32,       32'h0,   1'b0, 32'h80000001, 1'b1}, // R11 ror 32
        '{4'd11, 32'h00000471, 32'h0000000F, 32'd36,       32'h0,   1'b0, 32'hF0000000, 1'b1}  // R11 ror 36
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        instr = v.ins; rm_val = v.rm; rs_val = v.rs; pc_val = v.pc; carry_in = v.ci;
        in_valid = 1'b1;
    endtask

    task automatic check_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        check(tag, "valid", 32'(out_valid), 32'd1);
        check(tag, "operand", operand, v.op);
        check(tag, "carry", 32'(carry_out), 32'(v.co));
    endtask

    initial begin
        // R13: reset held low while a valid input is offered
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        check("R13", "valid in reset", 32'(out_valid), 32'd0);
        check("R13", "operand in reset", operand, 32'd0);
        rst_n = 1'b1;

        // Table walk, back to back
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R11: a larger multiple of 32, then idle hold (R12)
        drive('{4'd11, 32'h00000471, 32'h12345678, 32'd64, 32'h0, 1'b1, 32'h12345678, 1'b0});
        @(negedge clk);
        check("R11", "ror 64 operand", operand, 32'h12345678);
        check("R11", "ror 64 carry", 32'(carry_out), 32'd0);
        drive(VECS[0]);
        in_valid = 1'b0;
        @(negedge clk);
        check("R12", "idle valid", 32'(out_valid), 32'd0);
        check("R12", "idle operand held", operand, 32'h12345678);
        check("R12", "idle carry held", 32'(carry_out), 32'd0);

        // R12: single accepted input, one-cycle latency
        drive(VECS[2]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R12", "latency operand", operand, 32'hC000000F);
        check("R12", "latency valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R12", "valid drops", 32'(out_valid), 32'd0);

        // R13: reset mid-run coinciding with a valid input
        drive(VECS[8]);
        @(negedge clk);
        check("R13", "pre-reset valid", 32'(out_valid), 32'd1);
        rst_n = 1'b0;
        drive(VECS[10]);
        @(negedge clk);
        check("R13", "valid cleared", 32'(out_valid), 32'd0);
        check("R13", "operand cleared", operand, 32'd0);
        check("R13", "carry cleared", 32'(carry_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec(VECS[10]);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 10000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule